// File: doc/BRIEF.md
# VPW Bus Symbol Timing Classifier

This block sits on the receive side of a single-wire, variable-pulse-width serial bus. It brings the raw bus level into the local clock domain and times every active pulse and every passive gap in prescaled ticks. At each level change it reports what the phase that just ended was. Active pulses are reported as a too-short or too-long invalid pulse, a data 0, a data 1 or a start-of-frame. Passive gaps are reported as an invalid glitch, a data 1, a data 0, an end-of-data or an end-of-frame.

While the bus stays passive, the block raises strobes as the gap crosses the end-of-frame, inter-frame-separation and idle thresholds. A frame-boundary state machine follows these strobes and drives a level `tx_allowed_o` that tells a local transmitter when it may start driving the bus. Transmission is allowed once the separation time is reached. It is also allowed early when the transmitter has a message pending and another node starts a frame after a valid end-of-frame, so the local node joins arbitration at once. An invalid symbol aborts the frame: no early start is granted until a fresh end-of-frame has been observed.

Top module: `vpw_sym_classifier`

## Requirements
- R1: While `rst_ni` is low and right after its release, `sym_valid_o`, `eof_det_o`, `ifs_det_o`, `idle_det_o` and `tx_allowed_o` are all low.
- R2: At the end of an active pulse of w ticks, one `sym_valid_o` strobe reports `sym_code_o` = 0 (invalid) for w < ACT_INV_T, 1 (data 0) for ACT_INV_T <= w < ACT_BIT_T, 2 (data 1) for ACT_BIT_T <= w < ACT_SOF_T, 3 (start-of-frame) for ACT_SOF_T <= w < ACT_MAX_T, and 0 for w >= ACT_MAX_T.
- R3: At the end of a passive gap of w ticks, one strobe reports code 0 for w < PAS_INV_T, 2 (data 1) for PAS_INV_T <= w < PAS_BIT_T, 1 (data 0) for PAS_BIT_T <= w < PAS_EOD_T, 4 (end-of-data) for PAS_EOD_T <= w < PAS_EOF_T, and 5 (end-of-frame) for w >= PAS_EOF_T.
- R4: A passive gap that reaches PAS_EOF_T ticks produces exactly one `eof_det_o` pulse before the gap ends.
- R5: A gap that continues after end-of-frame to PAS_IFS_T ticks produces exactly one `ifs_det_o` pulse.
- R6: A gap that continues after separation to PAS_IDLE_T ticks produces exactly one `idle_det_o` pulse, and the bus stays open for transmission.
- R7: `tx_allowed_o` is low between end-of-frame and the separation threshold. It is high from the separation strobe until the next passive-to-active edge. It drops at that edge when no message is pending.
- R8: A passive-to-active edge after a valid end-of-frame while `tx_pending_i` is high raises (or keeps) `tx_allowed_o` until `tx_pending_i` falls.
- R9: After an invalid symbol, a passive-to-active edge with `tx_pending_i` high leaves `tx_allowed_o` low until a new end-of-frame is detected.
- R10: The duration counter saturates. A phase of any length beyond the largest threshold is classified as if it had lasted exactly that long: an invalid active pulse or an end-of-frame gap. It is never classified as a wrapped short value.
- R11: No two of the four strobes are high in the same cycle, and every level change of the bus produces exactly one symbol strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_i | input | 1 | Raw bus receive level, asynchronous |
| tx_pending_i | input | 1 | Local transmitter has a message waiting |
| sym_valid_o | output | 1 | One-cycle strobe: a phase ended and was classified |
| sym_code_o | output | 3 | Class of the ended phase (codes in R2, R3) |
| eof_det_o | output | 1 | One-cycle strobe: gap reached end-of-frame length |
| ifs_det_o | output | 1 | One-cycle strobe: gap reached separation length |
| idle_det_o | output | 1 | One-cycle strobe: gap reached idle length |
| tx_allowed_o | output | 1 | Level: local transmitter may start driving |

## Verification
The hardest situation to reach is the early start. The state machine must sit in the end-of-frame window, between PAS_EOF_T and PAS_IFS_T, when a passive-to-active edge arrives with a message pending. The bench holds a gap of 270 ticks and raises `tx_pending_i` just before the edge. It then repeats the edge after an invalid pulse, to show that the aborted state grants nothing. Counter saturation is reached by 700-tick phases. If the counter wrapped instead, the result would look like a start-of-frame.

// File: rtl/vpw_sym_pkg.sv
package vpw_sym_pkg;

  typedef enum logic [2:0] {
    SYM_INVALID = 3'd0,
    SYM_BIT0    = 3'd1,
    SYM_BIT1    = 3'd2,
    SYM_SOF     = 3'd3,
    SYM_EOD     = 3'd4,
    SYM_EOF     = 3'd5
  } sym_code_e;

  typedef enum logic [2:0] {
    FR_WAIT = 3'd0,  // aborted, no valid end-of-frame yet
    FR_DATA = 3'd1,
    FR_EOF  = 3'd2,
    FR_IFS  = 3'd3,
    FR_IDLE = 3'd4
  } frame_st_e;

endpackage

// File: rtl/vpw_sync_edge.sv
module vpw_sync_edge #(
  parameter bit ACTIVE_HIGH = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_i,
  output logic act_o,
  output logic rise_o,
  output logic fall_o
);

  logic       raw_act;
  logic [1:0] sync_q;
  logic       lvl_q;

  generate
    if (ACTIVE_HIGH) begin : g_pol_hi
      assign raw_act = bus_i;
    end else begin : g_pol_lo
      assign raw_act = ~bus_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b00;
      lvl_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], raw_act};
      lvl_q  <= sync_q[1];
    end
  end

  assign act_o  = lvl_q;
  assign rise_o = sync_q[1] & ~lvl_q;
  assign fall_o = ~sync_q[1] & lvl_q;

  // R11
  edge_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_o |=> act_o) and (fall_o |=> !act_o));

endmodule

// File: rtl/vpw_tick_timer.sv
module vpw_tick_timer #(
  parameter int PRESCALE = 100,
  parameter int CNT_W    = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             edge_i,
  output logic             tick_o,
  output logic [CNT_W-1:0] dur_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] dur_q;

  generate
    if (PRESCALE > 1) begin : g_presc
      localparam int PS_W = $clog2(PRESCALE);
      localparam logic [PS_W-1:0] PS_LAST = PS_W'(PRESCALE - 1);
      logic [PS_W-1:0] ps_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)             ps_q <= '0;
        else if (ps_q == PS_LAST) ps_q <= '0;
        else                     ps_q <= ps_q + 1'b1;
      end
      assign tick_o = (ps_q == PS_LAST);
    end else begin : g_nopresc
      assign tick_o = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        dur_q <= '0;
    else if (edge_i)                    dur_q <= '0;
    else if (tick_o && dur_q != CNT_MAX) dur_q <= dur_q + 1'b1;
  end

  assign dur_o = dur_q;

  // R10
  sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dur_q == CNT_MAX && !edge_i) |=> dur_q == CNT_MAX);

  // R10
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !edge_i |=> dur_q >= $past(dur_q));

endmodule

// File: rtl/vpw_sym_decode.sv
module vpw_sym_decode
  import vpw_sym_pkg::*;
#(
  parameter int CNT_W      = 9,
  parameter int ACT_INV_T  = 34,
  parameter int ACT_BIT_T  = 96,
  parameter int ACT_SOF_T  = 163,
  parameter int ACT_MAX_T  = 239,
  parameter int PAS_INV_T  = 34,
  parameter int PAS_BIT_T  = 96,
  parameter int PAS_EOD_T  = 163,
  parameter int PAS_EOF_T  = 239,
  parameter int PAS_IFS_T  = 300,
  parameter int PAS_IDLE_T = 500
) (
  input  logic             fall_i,
  input  logic             edge_i,
  input  logic             act_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] dur_i,
  output sym_code_e        code_o,
  output logic             hit_eof_o,
  output logic             hit_ifs_o,
  output logic             hit_idle_o
);

  localparam logic [CNT_W-1:0] A_INV  = CNT_W'(ACT_INV_T);
  localparam logic [CNT_W-1:0] A_BIT  = CNT_W'(ACT_BIT_T);
  localparam logic [CNT_W-1:0] A_SOF  = CNT_W'(ACT_SOF_T);
  localparam logic [CNT_W-1:0] A_MAX  = CNT_W'(ACT_MAX_T);
  localparam logic [CNT_W-1:0] P_INV  = CNT_W'(PAS_INV_T);
  localparam logic [CNT_W-1:0] P_BIT  = CNT_W'(PAS_BIT_T);
  localparam logic [CNT_W-1:0] P_EOD  = CNT_W'(PAS_EOD_T);
  localparam logic [CNT_W-1:0] P_EOF  = CNT_W'(PAS_EOF_T);
  // live crossings fire one tick before the counter reaches the threshold
  localparam logic [CNT_W-1:0] X_EOF  = CNT_W'(PAS_EOF_T - 1);
  localparam logic [CNT_W-1:0] X_IFS  = CNT_W'(PAS_IFS_T - 1);
  localparam logic [CNT_W-1:0] X_IDLE = CNT_W'(PAS_IDLE_T - 1);

  sym_code_e act_code, pas_code;
  logic      live;

  always_comb begin
    if (dur_i < A_INV)      act_code = SYM_INVALID;
    else if (dur_i < A_BIT) act_code = SYM_BIT0;
    else if (dur_i < A_SOF) act_code = SYM_BIT1;
    else if (dur_i < A_MAX) act_code = SYM_SOF;
    else                    act_code = SYM_INVALID;
  end

  always_comb begin
    if (dur_i < P_INV)      pas_code = SYM_INVALID;
    else if (dur_i < P_BIT) pas_code = SYM_BIT1;
    else if (dur_i < P_EOD) pas_code = SYM_BIT0;
    else if (dur_i < P_EOF) pas_code = SYM_EOD;
    else                    pas_code = SYM_EOF;
  end

  assign code_o     = fall_i ? act_code : pas_code;
  assign live       = tick_i && !act_i && !edge_i;
  assign hit_eof_o  = live && (dur_i == X_EOF);
  assign hit_ifs_o  = live && (dur_i == X_IFS);
  assign hit_idle_o = live && (dur_i == X_IDLE);

endmodule

// File: rtl/vpw_frame_fsm.sv
module vpw_frame_fsm
  import vpw_sym_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      rise_i,
  input  logic      fall_i,
  input  sym_code_e code_i,
  input  logic      hit_eof_i,
  input  logic      hit_ifs_i,
  input  logic      hit_idle_i,
  input  logic      tx_pending_i,
  output logic      sym_valid_o,
  output sym_code_e sym_code_o,
  output logic      eof_det_o,
  output logic      ifs_det_o,
  output logic      idle_det_o,
  output logic      tx_allowed_o
);

  frame_st_e st_q, st_d;
  logic      grant_q;
  logic      sym_err, after_eof;

  assign sym_err   = (rise_i || fall_i) && (code_i == SYM_INVALID);
  assign after_eof = (st_q == FR_EOF) || (st_q == FR_IFS) || (st_q == FR_IDLE);

  always_comb begin
    st_d = st_q;
    if (sym_err)                                           st_d = FR_WAIT;
    else if (rise_i && after_eof)                          st_d = FR_DATA;
    else if (hit_eof_i && (st_q == FR_WAIT || st_q == FR_DATA)) st_d = FR_EOF;
    else if (hit_ifs_i && st_q == FR_EOF)                  st_d = FR_IFS;
    else if (hit_idle_i && st_q == FR_IFS)                 st_d = FR_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= FR_WAIT;
      grant_q     <= 1'b0;
      sym_valid_o <= 1'b0;
      sym_code_o  <= SYM_INVALID;
      eof_det_o   <= 1'b0;
      ifs_det_o   <= 1'b0;
      idle_det_o  <= 1'b0;
    end else begin
      st_q        <= st_d;
      sym_valid_o <= rise_i || fall_i;
      sym_code_o  <= code_i;
      eof_det_o   <= hit_eof_i && (st_q == FR_WAIT || st_q == FR_DATA);
      ifs_det_o   <= hit_ifs_i && (st_q == FR_EOF);
      idle_det_o  <= hit_idle_i && (st_q == FR_IFS);
      if (!tx_pending_i || sym_err)  grant_q <= 1'b0;
      else if (rise_i && after_eof)  grant_q <= 1'b1;
    end
  end

  assign tx_allowed_o = (st_q == FR_IFS) || (st_q == FR_IDLE) || grant_q;

  // R11
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sym_valid_o, eof_det_o, ifs_det_o, idle_det_o}));

  // R2
  act_code_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_i |-> (code_i != SYM_EOD && code_i != SYM_EOF));

  // R5
  ifs_after_eof_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ifs_det_o |-> $past(st_q) == FR_EOF);

  // R7
  ifs_opens_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ifs_det_o |-> tx_allowed_o);

  // R9
  abort_no_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == FR_WAIT && rise_i) |=> !grant_q);

  // R8
  grant_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_pending_i |=> !grant_q);

endmodule

// File: rtl/vpw_sym_classifier.sv
module vpw_sym_classifier
  import vpw_sym_pkg::*;
#(
  parameter int PRESCALE    = 100,
  parameter bit ACTIVE_HIGH = 1'b1,
  parameter int ACT_INV_T   = 34,
  parameter int ACT_BIT_T   = 96,
  parameter int ACT_SOF_T   = 163,
  parameter int ACT_MAX_T   = 239,
  parameter int PAS_INV_T   = 34,
  parameter int PAS_BIT_T   = 96,
  parameter int PAS_EOD_T   = 163,
  parameter int PAS_EOF_T   = 239,
  parameter int PAS_IFS_T   = 300,
  parameter int PAS_IDLE_T  = 500
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bus_i,
  input  logic       tx_pending_i,
  output logic       sym_valid_o,
  output logic [2:0] sym_code_o,
  output logic       eof_det_o,
  output logic       ifs_det_o,
  output logic       idle_det_o,
  output logic       tx_allowed_o
);

  localparam int MAX_T = (PAS_IDLE_T > ACT_MAX_T) ? PAS_IDLE_T : ACT_MAX_T;
  localparam int CNT_W = $clog2(MAX_T + 2);

  logic             act, rise, fall, edge_any, tick;
  logic [CNT_W-1:0] dur;
  sym_code_e        code, code_q;
  logic             hit_eof, hit_ifs, hit_idle;

  assign edge_any = rise | fall;

  vpw_sync_edge #(.ACTIVE_HIGH(ACTIVE_HIGH)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .bus_i (bus_i),
    .act_o (act),
    .rise_o(rise),
    .fall_o(fall)
  );

  vpw_tick_timer #(.PRESCALE(PRESCALE), .CNT_W(CNT_W)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .edge_i(edge_any),
    .tick_o(tick),
    .dur_o (dur)
  );

  vpw_sym_decode #(
    .CNT_W(CNT_W),
    .ACT_INV_T(ACT_INV_T), .ACT_BIT_T(ACT_BIT_T), .ACT_SOF_T(ACT_SOF_T), .ACT_MAX_T(ACT_MAX_T),
    .PAS_INV_T(PAS_INV_T), .PAS_BIT_T(PAS_BIT_T), .PAS_EOD_T(PAS_EOD_T), .PAS_EOF_T(PAS_EOF_T),
    .PAS_IFS_T(PAS_IFS_T), .PAS_IDLE_T(PAS_IDLE_T)
  ) u_decode (
    .fall_i    (fall),
    .edge_i    (edge_any),
    .act_i     (act),
    .tick_i    (tick),
    .dur_i     (dur),
    .code_o    (code),
    .hit_eof_o (hit_eof),
    .hit_ifs_o (hit_ifs),
    .hit_idle_o(hit_idle)
  );

  vpw_frame_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rise_i      (rise),
    .fall_i      (fall),
    .code_i      (code),
    .hit_eof_i   (hit_eof),
    .hit_ifs_i   (hit_ifs),
    .hit_idle_i  (hit_idle),
    .tx_pending_i(tx_pending_i),
    .sym_valid_o (sym_valid_o),
    .sym_code_o  (code_q),
    .eof_det_o   (eof_det_o),
    .ifs_det_o   (ifs_det_o),
    .idle_det_o  (idle_det_o),
    .tx_allowed_o(tx_allowed_o)
  );

  assign sym_code_o = code_q;

  // R3
  code_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_valid_o |-> sym_code_o <= 3'd5);

endmodule

// File: tb/vpw_sym_classifier_bench.sv
module vpw_sym_classifier_bench;

  localparam int PS = 4;

  logic       clk = 1'b0;
  logic       rst_n, bus, tx_pend;
  logic       sym_valid, eof_det, ifs_det, idle_det, tx_allowed;
  logic [2:0] sym_code;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct { int ev; string req; } item_t;
  item_t expq[$];

  // event encoding: kind*8 + code; kind 1 symbol, 2 eof, 3 ifs, 4 idle
  localparam int K_SYM = 8, K_EOF = 16, K_IFS = 24, K_IDLE = 32;
  localparam int C_INV = 0, C_B0 = 1, C_B1 = 2, C_SOF = 3, C_EOD = 4, C_EOF = 5;

  always #5 clk = ~clk;

  vpw_sym_classifier #(.PRESCALE(PS)) u_vpw_sym_classifier (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .bus_i       (bus),
    .tx_pending_i(tx_pend),
    .sym_valid_o (sym_valid),
    .sym_code_o  (sym_code),
    .eof_det_o   (eof_det),
    .ifs_det_o   (ifs_det),
    .idle_det_o  (idle_det),
    .tx_allowed_o(tx_allowed)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input int ev, input string req);
    item_t it;
    it.ev  = ev;
    it.req = req;
    expq.push_back(it);
  endtask

  task automatic hold(input bit lvl, input int ticks);
    @(negedge clk);
    bus = lvl;
    repeat (ticks * PS - 1) @(negedge clk);
  endtask

  task automatic observe(input int ev);
    item_t it;
    if (expq.size() == 0) begin
      chk(1'b0, "R11 unexpected event", ev, -1);
    end else begin
      it = expq.pop_front();
      chk(ev == it.ev, it.req, ev, it.ev);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (sym_valid) observe(K_SYM + int'(sym_code));
      if (eof_det)   observe(K_EOF);
      if (ifs_det)   observe(K_IFS);
      if (idle_det)  observe(K_IDLE);
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "R11 watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus = 1'b0; tx_pend = 1'b0;
    repeat (5) @(negedge clk);
    chk(!sym_valid && !eof_det && !ifs_det && !idle_det, "R1 strobes in reset", int'(sym_valid), 0);
    chk(!tx_allowed, "R1 tx_allowed in reset", int'(tx_allowed), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!tx_allowed, "R1 tx_allowed after release", int'(tx_allowed), 0);

    // long quiet bus from reset
    push(K_EOF, "R4 eof from reset"); push(K_IFS, "R5 ifs from reset"); push(K_IDLE, "R6 idle from reset");
    hold(1'b0, 600);
    chk(tx_allowed, "R6 idle opens bus", int'(tx_allowed), 1);

    // frame seen by a node with nothing pending
    push(K_SYM + C_EOF, "R3 long gap end-of-frame");
    hold(1'b1, 5);
    chk(!tx_allowed, "R7 closes at edge without pending", int'(tx_allowed), 0);
    hold(1'b1, 195);
    push(K_SYM + C_SOF, "R2 start-of-frame 200");
    hold(1'b0, 64);
    push(K_SYM + C_B1, "R3 short gap data 1");
    hold(1'b1, 64);
    push(K_SYM + C_B0, "R2 short pulse data 0");
    hold(1'b0, 128);
    push(K_SYM + C_B0, "R3 long gap data 0");
    hold(1'b1, 128);
    push(K_SYM + C_B1, "R2 long pulse data 1");
    hold(1'b0, 200);
    push(K_SYM + C_EOD, "R3 end-of-data gap");
    hold(1'b1, 64);
    push(K_SYM + C_B0, "R2 data 0 before eof");
    push(K_EOF, "R4 eof in frame");
    hold(1'b0, 270);
    chk(!tx_allowed, "R7 closed inside eof window", int'(tx_allowed), 0);

    // early start inside end-of-frame window
    tx_pend = 1'b1;
    push(K_SYM + C_EOF, "R3 eof gap 270");
    hold(1'b1, 10);
    chk(tx_allowed, "R8 early grant after eof", int'(tx_allowed), 1);
    hold(1'b1, 190);
    push(K_SYM + C_SOF, "R2 sof on granted edge");
    tx_pend = 1'b0;
    hold(1'b0, 64);
    chk(!tx_allowed, "R8 grant released", int'(tx_allowed), 0);
    push(K_SYM + C_B1, "R3 data 1");
    hold(1'b1, 128);
    push(K_SYM + C_B1, "R2 data 1");

    // separation window, pending edge keeps bus open
    push(K_EOF, "R4 eof"); push(K_IFS, "R5 ifs");
    hold(1'b0, 350);
    chk(tx_allowed, "R7 open after ifs", int'(tx_allowed), 1);
    tx_pend = 1'b1;
    push(K_SYM + C_EOF, "R3 eof gap 350");
    hold(1'b1, 10);
    chk(tx_allowed, "R8 grant in ifs window", int'(tx_allowed), 1);
    hold(1'b1, 54);
    tx_pend = 1'b0;
    push(K_SYM + C_B0, "R2 data 0");

    // abort by short pulse, then no early grant
    hold(1'b0, 64);
    push(K_SYM + C_B1, "R3 data 1");
    hold(1'b1, 10);
    push(K_SYM + C_INV, "R2 too short pulse");
    hold(1'b0, 64);
    tx_pend = 1'b1;
    push(K_SYM + C_B1, "R3 data 1 after abort");
    hold(1'b1, 10);
    chk(!tx_allowed, "R9 no grant after abort", int'(tx_allowed), 0);
    hold(1'b1, 90);
    tx_pend = 1'b0;
    push(K_SYM + C_B1, "R2 pulse 100 data 1");
    hold(1'b0, 10);
    push(K_SYM + C_INV, "R3 glitch gap");
    hold(1'b1, 64);
    push(K_SYM + C_B0, "R2 data 0");
    hold(1'b0, 64);
    push(K_SYM + C_B1, "R3 data 1");
    hold(1'b1, 260);
    push(K_SYM + C_INV, "R2 too long pulse");
    hold(1'b0, 64);
    push(K_SYM + C_B1, "R3 data 1");

    // saturation: 700 would wrap to 188 (start-of-frame) without it
    hold(1'b1, 700);
    push(K_SYM + C_INV, "R10 saturated pulse invalid");
    push(K_EOF, "R4 eof after abort"); push(K_IFS, "R5 ifs"); push(K_IDLE, "R6 idle");
    hold(1'b0, 700);
    chk(tx_allowed, "R6 open after long idle", int'(tx_allowed), 1);
    push(K_SYM + C_EOF, "R10 saturated gap eof");
    hold(1'b1, 64);
    push(K_SYM + C_B0, "R2 final data 0");
    hold(1'b0, 40);
    repeat (20) @(negedge clk);
    chk(expq.size() == 0, "R11 missing events", expq.size(), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule